// File: doc/BRIEF.md
# UART Interrupt Identification Arbiter

This block sits between the five interrupt sources of a UART and the host-facing interrupt line. Each source gives a one-cycle set pulse when its event occurs and a one-cycle clear pulse when software services it. The block keeps one pending flag per source and masks each flag with its enable bit. It then picks the highest-priority unmasked flag. From that choice it forms the interrupt identification byte that the host reads, and it drives the single interrupt request.

An event that arrives while its enable is off is not lost. It stays pending but hidden, and it produces no request and no identification code. When software later turns the enable on, the hidden event becomes visible. Turning the enable off again hides it. The request leaves the block only while the modem-control output gate is set. The identification byte also shows whether FIFO mode is on.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset no event is pending, `irqOut` is 0 and `idByte` reads 0x01 (0xC1 when `fifoMode` is 1).
- R2: `idByte` bit 0 is 0 exactly when some unmasked event is pending. Bits 3:1 hold the 3-bit code of the chosen source. Bits 5:4 read 0. Bits 7:6 read 11 when `fifoMode` is 1 and 00 otherwise. With nothing unmasked, the code is 0.
- R3: Sources are indexed 0 line status, 1 receive timeout, 2 received data, 3 transmit empty, 4 modem status. This order is also the priority order, highest first. Their codes are 3, 6, 2, 1 and 0.
- R4: `irqEnable` bit 0 unmasks both received data and receive timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. An event set while masked gives no request, and it does not appear in `idByte`.
- R5: When an enable bit goes from 0 to 1, its latent events become active in the same cycle: `irqOut` rises and `idByte` shows the code.
- R6: When an enable bit goes from 1 to 0, its active events return to latent. The request is re-evaluated from the events that remain, and re-enabling restores them.
- R7: `irqOut` is 1 only while `out2Gate` is 1. `idByte` does not depend on `out2Gate`.
- R8: `irqOut` falls only when no unmasked event is pending. Clearing the chosen source exposes the next one in priority order.
- R9: When the set and clear pulses of one source arrive in the same cycle, the event ends up pending.
- R10: A clear pulse also removes a latent event, so a later enable raises nothing for it.
- R11: A set or clear pulse sampled at a clock edge shows on the outputs right after that edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setPulse | input | 5 | Per-source event pulses, indexed as in R3 |
| clrPulse | input | 5 | Per-source service pulses, indexed as in R3 |
| irqEnable | input | 4 | Enable register bits, mapped as in R4 |
| fifoMode | input | 1 | FIFO mode on, reported in idByte bits 7:6 |
| out2Gate | input | 1 | Modem-control gate for the request line |
| irqOut | output | 1 | Interrupt request |
| idByte | output | 8 | Interrupt identification byte |

## Verification
Three things can fall in the same cycle: a source's set pulse, its own clear pulse, and a change of the enable bit. The set pulse and its clear pulse are driven together for one source under an open mask. The bench then checks that the flag stays pending and that the code remains readable. An enable bit is also dropped and raised with no pulses at all. Here the bench judges that the request and code follow the mask in that same cycle, while the hidden flag survives.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_COUNT = 5;
  localparam int IER_BITS  = 4;
  localparam int ID_BITS   = 3;
  localparam int SEL_BITS  = $clog2(SRC_COUNT);

  typedef enum logic [SEL_BITS-1:0] {
    SRC_LINE  = 3'd0,
    SRC_TMO   = 3'd1,
    SRC_RXD   = 3'd2,
    SRC_TXE   = 3'd3,
    SRC_MODEM = 3'd4
  } srcIdx_e;

  typedef struct packed {
    logic [SRC_COUNT-1:0] raise;
    logic [SRC_COUNT-1:0] drop;
  } flagStrobe_t;

  function automatic logic [ID_BITS-1:0] codeOf(input logic [SEL_BITS-1:0] idx);
    case (idx)
      SRC_LINE:  codeOf = 3'd3;
      SRC_TMO:   codeOf = 3'd6;
      SRC_RXD:   codeOf = 3'd2;
      SRC_TXE:   codeOf = 3'd1;
      default:   codeOf = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uart_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStrobe_t          stb,
  output logic [SRC_COUNT-1:0] pendFlags
);
  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)              pendFlags[i] <= 1'b0;
      else if (stb.raise[i])  pendFlags[i] <= 1'b1;
      else if (stb.drop[i])   pendFlags[i] <= 1'b0;
    end

    // R9: a raise strobe always leaves the flag pending
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      stb.raise[i] |=> pendFlags[i]);
    // R10: a drop without raise clears the flag, latent or not
    p_drop_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
      (stb.drop[i] && !stb.raise[i]) |=> !pendFlags[i]);
    // R11: flags move only on strobes
    p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.raise[i] && !stb.drop[i]) |=> $stable(pendFlags[i]));
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] setPulse,
  input  logic [SRC_COUNT-1:0] clrPulse,
  input  logic [IER_BITS-1:0]  irqEnable,
  input  logic                 fifoMode,
  input  logic                 out2Gate,
  input  logic [SRC_COUNT-1:0] pendFlags,
  output flagStrobe_t          stb,
  output logic                 irqOut,
  output logic [7:0]           idByte
);
  logic [SRC_COUNT-1:0] srcMask;
  logic [SRC_COUNT-1:0] liveFlags;
  logic [SEL_BITS-1:0]  winner;
  logic                 anyLive;

  // set wins over clear for the same source
  always_comb begin
    stb.raise = setPulse;
    stb.drop  = clrPulse & ~setPulse;
  end

  // enable register bits onto source positions
  always_comb begin
    srcMask            = '0;
    srcMask[SRC_LINE]  = irqEnable[2];
    srcMask[SRC_TMO]   = irqEnable[0];
    srcMask[SRC_RXD]   = irqEnable[0];
    srcMask[SRC_TXE]   = irqEnable[1];
    srcMask[SRC_MODEM] = irqEnable[3];
  end

  assign liveFlags = pendFlags & srcMask;
  assign anyLive   = |liveFlags;

  // lowest index has the highest priority
  always_comb begin
    winner = SEL_BITS'(SRC_MODEM);
    for (int i = SRC_COUNT - 1; i >= 0; i--) begin
      if (liveFlags[i]) winner = SEL_BITS'(i);
    end
  end

  always_comb begin
    idByte      = '0;
    idByte[7:6] = {2{fifoMode}};
    idByte[3:1] = anyLive ? codeOf(winner) : 3'd0;
    idByte[0]   = ~anyLive;
  end

  assign irqOut = out2Gate & anyLive;

  // R7: no request without the output gate
  p_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !out2Gate |-> !irqOut);
  // R2: a request always shows as pending in the byte
  p_pending_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !idByte[0]);
  // R2: mode bits follow the FIFO mode
  p_mode_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    idByte[7:6] == {2{fifoMode}} && idByte[5:4] == 2'b00);
  // R3: an unmasked line status event always wins
  p_line_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlags[SRC_LINE] && irqEnable[2]) |-> idByte[3:1] == 3'd3);
  // R2: idle byte carries code 0
  p_idle_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    idByte[0] |-> idByte[3:1] == 3'd0);
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] setPulse,
  input  logic [4:0] clrPulse,
  input  logic [3:0] irqEnable,
  input  logic       fifoMode,
  input  logic       out2Gate,
  output logic       irqOut,
  output logic [7:0] idByte
);
  flagStrobe_t          stb;
  logic [SRC_COUNT-1:0] pendFlags;

  uart_irq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .setPulse  (setPulse),
    .clrPulse  (clrPulse),
    .irqEnable (irqEnable),
    .fifoMode  (fifoMode),
    .out2Gate  (out2Gate),
    .pendFlags (pendFlags),
    .stb       (stb),
    .irqOut    (irqOut),
    .idByte    (idByte)
  );

  uart_irq_flags i_flags (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pendFlags (pendFlags)
  );
endmodule

// File: tb/test_uart_irq_arbiter.sv
module test_uart_irq_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] setPulse = '0;
  logic [4:0] clrPulse = '0;
  logic [3:0] irqEnable = '0;
  logic       fifoMode = 1'b0;
  logic       out2Gate = 1'b1;
  logic       irqOut;
  logic [7:0] idByte;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  uart_irq_arbiter i_uart_irq_arbiter (
    .clk(clk), .rstN(rstN), .setPulse(setPulse), .clrPulse(clrPulse),
    .irqEnable(irqEnable), .fifoMode(fifoMode), .out2Gate(out2Gate),
    .irqOut(irqOut), .idByte(idByte)
  );

  // fields: set, clr, enable, fifo, gate, expected byte, expected request
  localparam int NV = 21;
  localparam logic [24:0] VEC [NV] = '{
    {5'h08, 5'h00, 4'h2, 1'b0, 1'b1, 8'h02, 1'b1},  // R4 tx only
    {5'h10, 5'h00, 4'hA, 1'b0, 1'b1, 8'h02, 1'b1},  // R3 tx over modem
    {5'h04, 5'h00, 4'hB, 1'b0, 1'b1, 8'h04, 1'b1},  // R3 rx over tx
    {5'h02, 5'h00, 4'hB, 1'b0, 1'b1, 8'h0C, 1'b1},  // R3 timeout over rx
    {5'h01, 5'h00, 4'hF, 1'b1, 1'b1, 8'hC6, 1'b1},  // R3 R2 line first, fifo bits
    {5'h00, 5'h01, 4'hF, 1'b1, 1'b1, 8'hCC, 1'b1},  // R8 next is timeout
    {5'h00, 5'h02, 4'hF, 1'b1, 1'b1, 8'hC4, 1'b1},  // R8
    {5'h00, 5'h04, 4'hF, 1'b1, 1'b1, 8'hC2, 1'b1},  // R8
    {5'h00, 5'h08, 4'hF, 1'b1, 1'b1, 8'hC0, 1'b1},  // R8 modem code 0
    {5'h00, 5'h00, 4'hF, 1'b1, 1'b0, 8'hC0, 1'b0},  // R7 gate off
    {5'h00, 5'h10, 4'hF, 1'b1, 1'b1, 8'hC1, 1'b0},  // R8 all clear
    {5'h04, 5'h00, 4'h0, 1'b0, 1'b1, 8'h01, 1'b0},  // R4 masked rx
    {5'h02, 5'h00, 4'h0, 1'b0, 1'b1, 8'h01, 1'b0},  // R4 masked timeout
    {5'h00, 5'h00, 4'h1, 1'b0, 1'b1, 8'h0C, 1'b1},  // R5 replay
    {5'h00, 5'h00, 4'h0, 1'b0, 1'b1, 8'h01, 1'b0},  // R6 back to latent
    {5'h00, 5'h02, 4'h0, 1'b0, 1'b1, 8'h01, 1'b0},  // R10 clear latent
    {5'h00, 5'h00, 4'h1, 1'b0, 1'b1, 8'h04, 1'b1},  // R10 R6 only rx returns
    {5'h04, 5'h04, 4'h1, 1'b0, 1'b1, 8'h04, 1'b1},  // R9 set wins
    {5'h00, 5'h04, 4'h1, 1'b0, 1'b1, 8'h01, 1'b0},  // R8
    {5'h01, 5'h01, 4'h4, 1'b0, 1'b1, 8'h06, 1'b1},  // R9 line
    {5'h00, 5'h01, 4'h4, 1'b0, 1'b1, 8'h01, 1'b0}   // R8
  };

  task automatic check(input string req, input logic [7:0] expId, input logic expIrq);
    checkCount++;
    if (idByte !== expId || irqOut !== expIrq) begin
      failCount++;
      $display("FAIL %s: idByte=%h irqOut=%b expected idByte=%h irqOut=%b",
               req, idByte, irqOut, expId, expIrq);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1 check("R1 reset", 8'h01, 1'b0);
    fifoMode = 1'b1;
    #1 check("R1 reset fifo", 8'hC1, 1'b0);
    fifoMode = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {setPulse, clrPulse, irqEnable, fifoMode, out2Gate} = VEC[v][24:9];
      @(posedge clk);
      #2 check($sformatf("vector %0d", v), VEC[v][8:1], VEC[v][0]);
    end

    // R11: pulse not visible before the edge, visible after
    @(negedge clk);
    setPulse = 5'h08; clrPulse = '0; irqEnable = 4'h2; out2Gate = 1'b1; fifoMode = 1'b0;
    #1 check("R11 before edge", 8'h01, 1'b0);
    @(posedge clk);
    #2 check("R11 after edge", 8'h02, 1'b1);
    @(negedge clk) setPulse = '0;
    // R7: gate does not alter the byte
    out2Gate = 1'b0;
    #1 check("R7 byte kept", 8'h02, 1'b0);
    out2Gate = 1'b1;
    // R1: reset drops pending events, latent ones too
    setPulse = 5'h10; irqEnable = 4'h2;
    @(posedge clk);
    @(negedge clk) setPulse = '0; rstN = 1'b0;
    @(posedge clk);
    @(negedge clk) rstN = 1'b1; irqEnable = 4'hF;
    #1 check("R1 reset clears", 8'h01, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule